// File: doc/BRIEF.md
# MMU Translation Storage Buffer Pointer Register Unit

This block holds the translation-storage-buffer configuration and the tag access register for a pair of memory management units, one for instruction fetch and one for data. From those two stored values it derives three read-only words per unit: the pointer into the buffer for an 8 KB page, the pointer for a 64 KB page, and the tag target word that software compares against a buffer entry.

All access goes through one register port. A request carries an address-space identifier (ASI) and an offset. The register index is offset bits [6:3]. A register-file ASI reaches the stored registers of one unit. Two further ASIs per unit return the computed pointers. The pointers and the tag target are formed combinationally from the stored registers and are captured into the response register one clock after the read request.

Top module: `tsb_ptr_unit`

## Requirements
- R1: After reset, rsp_valid_o and rsp_data_o are 0, and every stored register reads back 0.
- R2: A write to a register-file ASI (0x50 instruction, 0x58 data) at a non-zero index stores req_wdata_i. A later read of that index returns the value. Index 5 is the buffer configuration and index 6 is the tag access register.
- R3: A read of index 0 in a register-file ASI returns the tag target: tag access bits [12:0] placed at bits [60:48], ORed with the tag access register shifted right by 22. Writes to index 0 change nothing.
- R4: The 8 KB pointer (ASI 0x51 instruction, 0x59 data) is formed as follows. Clear tag access bits [12:0] and shift the result right by 9. Bits at or above 13+size+split come from the configuration register. Bits below that come from the shifted address. Bits [3:0] are zero. The size field is configuration bits [3:0] and the split flag is bit 12.
- R5: The 64 KB pointer (ASI 0x52 instruction, 0x5A data) is built the same way as the 8 KB pointer, with a shift of 12.
- R6: When the split flag is set, pointer bit 13+size is 0 for the 8 KB pointer and 1 for the 64 KB pointer. The boundary between base bits and address bits moves up one place.
- R7: Every size value from 0 to 15 moves the base/address boundary to bit 13+size when the split flag is clear.
- R8: Each unit's pointers and tag target depend only on that unit's own registers. Writes to one unit leave the other unit's read values unchanged.
- R9: rsp_valid_o is 1 in exactly the cycle after a valid read request. Write requests produce no response.
- R10: A read with any ASI other than the six listed returns 0.
- R11: Writes to the pointer ASIs have no effect on any stored register or computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_asi_i | input | 8 | Address-space identifier |
| req_off_i | input | 7 | Offset; bits [6:3] select the register index |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read request |
| rsp_data_o | output | 64 | Read data |

## Verification
The assertions check the following on every cycle:
- the one-cycle read response timing and the absence of responses to writes;
- zero data for unknown identifiers;
- the forced split bit and the cleared low nibble of each pointer;
- the placement of the context field in the tag target;
- that the stored configuration and tag registers hold when they are not addressed.

Some properties only the bench's scenarios can show:
- that the whole pointer value matches an independently computed reference across all sixteen sizes, both split settings and random register contents;
- that the two units stay isolated from each other;
- that writes to index 0 and to the pointer identifiers are discarded.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int DATA_W   = 64;
  localparam int ASI_W    = 8;
  localparam int OFF_W    = 7;
  localparam int IDX_W    = 4;
  localparam int IDX_LSB  = 3;
  localparam int CTX_W    = 13;
  localparam int NUM_MMU  = 2;
  localparam int SPLIT_BIT = 12;
  localparam int SIZE_W   = 4;
  localparam int TT_CTX_LSB = 48;
  localparam int TT_VA_SHIFT = 22;
  localparam int SHIFT_8K  = 9;
  localparam int SHIFT_64K = 12;

  localparam logic [IDX_W-1:0] IDX_TT   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_CFG  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_TAG  = 4'd6;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REG  = 2'd1,
    SEL_P8   = 2'd2,
    SEL_P64  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/tsb_mmu_regs.sv
module tsb_mmu_regs
  import tsb_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int IW   = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  output logic [W-1:0]  cfg_o,
  output logic [W-1:0]  tag_o
);
  localparam int NREG = 1 << IW;

  logic [W-1:0] regs_q [1:NREG-1];

  // index 0 has no storage: it is the computed tag target
  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(i))
        regs_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 1; i < NREG; i++)
      if (rd_idx_i == IW'(i)) rd_data_o = regs_q[i];
  end

  assign cfg_o = regs_q[int'(IDX_CFG)];
  assign tag_o = regs_q[int'(IDX_TAG)];

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == IDX_CFG) |=> $stable(cfg_o));
  assert_tag_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == IDX_TAG) |=> $stable(tag_o));
endmodule

// File: rtl/tsb_ptr_calc.sv
module tsb_ptr_calc
  import tsb_pkg::*;
#(
  parameter int W        = DATA_W,
  parameter bit BIG_PAGE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  input  logic [W-1:0] tag_i,
  output logic [W-1:0] ptr_o
);
  localparam int VA_SHIFT = BIG_PAGE ? SHIFT_64K : SHIFT_8K;
  localparam int POS_W    = $clog2(W);
  localparam logic [W-1:0] CTX_MASK = W'((64'd1 << CTX_W) - 64'd1);

  logic [SIZE_W-1:0] size;
  logic              split;
  logic [POS_W-1:0]  split_pos;
  logic [W-1:0]      base, mask, va, sel;

  assign size      = cfg_i[SIZE_W-1:0];
  assign split     = cfg_i[SPLIT_BIT];
  assign split_pos = POS_W'(CTX_W) + POS_W'(size);
  assign base      = cfg_i & ~CTX_MASK;
  assign sel       = W'(1) << split_pos;

  always_comb begin
    mask = ~CTX_MASK << size;
    if (split) mask = mask << 1;
    va = (tag_i & ~CTX_MASK) >> VA_SHIFT;
    if (split) va = BIG_PAGE ? (va | sel) : (va & ~sel);
  end

  assign ptr_o = ((base & mask) | (va & ~mask)) & ~W'(15);

  assert_split_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split |-> ptr_o[split_pos] == BIG_PAGE);
  assert_low_nibble_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[3:0] == 4'h0);
  assert_base_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[W-1:W-8] == cfg_i[W-1:W-8]);
endmodule

// File: rtl/tsb_tag_target.sv
module tsb_tag_target
  import tsb_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tag_i,
  output logic [W-1:0] tt_o
);
  assign tt_o = (W'(tag_i[CTX_W-1:0]) << TT_CTX_LSB) | (tag_i >> TT_VA_SHIFT);

  assert_tt_ctx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tt_o[TT_CTX_LSB+CTX_W-1:TT_CTX_LSB] == tag_i[CTX_W-1:0]);
  assert_tt_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tt_o[W-1:TT_CTX_LSB+CTX_W] == '0);
endmodule

// File: rtl/tsb_ptr_unit.sv
module tsb_ptr_unit
  import tsb_pkg::*;
#(
  parameter logic [ASI_W-1:0] I_REG_ASI = 8'h50,
  parameter logic [ASI_W-1:0] I_P8_ASI  = 8'h51,
  parameter logic [ASI_W-1:0] I_P64_ASI = 8'h52,
  parameter logic [ASI_W-1:0] D_REG_ASI = 8'h58,
  parameter logic [ASI_W-1:0] D_P8_ASI  = 8'h59,
  parameter logic [ASI_W-1:0] D_P64_ASI = 8'h5a
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ASI_W-1:0]  req_asi_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam logic [ASI_W-1:0] REG_ASI [NUM_MMU] = '{I_REG_ASI, D_REG_ASI};
  localparam logic [ASI_W-1:0] P8_ASI  [NUM_MMU] = '{I_P8_ASI,  D_P8_ASI};
  localparam logic [ASI_W-1:0] P64_ASI [NUM_MMU] = '{I_P64_ASI, D_P64_ASI};

  logic [IDX_W-1:0]  idx;
  logic              rd_req;
  logic              unused_off;
  logic [DATA_W-1:0] rf_rd [NUM_MMU];
  logic [DATA_W-1:0] cfg   [NUM_MMU];
  logic [DATA_W-1:0] tag   [NUM_MMU];
  logic [DATA_W-1:0] p8    [NUM_MMU];
  logic [DATA_W-1:0] p64   [NUM_MMU];
  logic [DATA_W-1:0] tt    [NUM_MMU];
  rd_sel_e           sel   [NUM_MMU];
  logic [DATA_W-1:0] rd_data;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign idx        = req_off_i[IDX_LSB +: IDX_W];
  assign unused_off = ^req_off_i[IDX_LSB-1:0];
  assign rd_req     = req_valid_i && !req_write_i;

  for (genvar m = 0; m < NUM_MMU; m++) begin : g_mmu
    logic wr_en;

    always_comb begin
      if (req_asi_i == REG_ASI[m])      sel[m] = SEL_REG;
      else if (req_asi_i == P8_ASI[m])  sel[m] = SEL_P8;
      else if (req_asi_i == P64_ASI[m]) sel[m] = SEL_P64;
      else                              sel[m] = SEL_NONE;
    end

    // tag target slot is read-only; pointer spaces take no writes
    assign wr_en = req_valid_i && req_write_i && sel[m] == SEL_REG && idx != IDX_TT;

    tsb_mmu_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (idx),
      .wr_data_i (req_wdata_i),
      .rd_idx_i  (idx),
      .rd_data_o (rf_rd[m]),
      .cfg_o     (cfg[m]),
      .tag_o     (tag[m])
    );

    tsb_ptr_calc #(.BIG_PAGE(1'b0)) u_p8 (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .cfg_i (cfg[m]), .tag_i (tag[m]), .ptr_o (p8[m])
    );

    tsb_ptr_calc #(.BIG_PAGE(1'b1)) u_p64 (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .cfg_i (cfg[m]), .tag_i (tag[m]), .ptr_o (p64[m])
    );

    tsb_tag_target u_tt (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .tag_i (tag[m]), .tt_o (tt[m])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int m = 0; m < NUM_MMU; m++) begin
      case (sel[m])
        SEL_REG:  rd_data = (idx == IDX_TT) ? tt[m] : rf_rd[m];
        SEL_P8:   rd_data = p8[m];
        SEL_P64:  rd_data = p64[m];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      if (rd_req) rsp_data_q <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  assert_rsp_after_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o);
  assert_no_rsp_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o);
  assert_unknown_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel[0] == SEL_NONE && sel[1] == SEL_NONE) |=> rsp_data_o == '0);
endmodule

// File: tb/tsb_ptr_unit_tb.sv
`timescale 1ns/1ps
module tsb_ptr_unit_tb_top;
  localparam logic [7:0] A_IREG = 8'h50, A_I8 = 8'h51, A_I64 = 8'h52;
  localparam logic [7:0] A_DREG = 8'h58, A_D8 = 8'h59, A_D64 = 8'h5a;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_asi = '0;
  logic [6:0]  req_off = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tsb_ptr_unit dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_write_i (req_write),
    .req_asi_i (req_asi), .req_off_i (req_off), .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data)
  );

  function automatic logic [63:0] ref_tt(input logic [63:0] tag);
    logic [63:0] r = '0;
    for (int i = 0; i < 13; i++) r[48+i] = tag[i];
    for (int i = 22; i < 64; i++) r[i-22] = r[i-22] | tag[i];
    return r;
  endfunction

  function automatic logic [63:0] ref_ptr(input logic [63:0] cfg, input logic [63:0] tag,
                                          input bit big);
    int size  = int'(cfg[3:0]);
    int split = int'(cfg[12]);
    int shft  = big ? 12 : 9;
    int bound = 13 + size + split;
    logic [63:0] r = '0;
    for (int i = 4; i < 64; i++) begin
      if (i >= bound) r[i] = cfg[i];
      else if (split == 1 && i == 13 + size) r[i] = big;
      else if (i + shft >= 13 && i + shft < 64) r[i] = tag[i+shft];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] asi, input int idx, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_asi = asi;
    req_off = 7'(idx << 3) | 7'(idx & 7 ? 3'b101 : 3'b000) ; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R9 no response to write", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic bus_read(input logic [7:0] asi, input int idx, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_asi = asi;
    req_off = 7'(idx << 3); req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 response valid one cycle after read", {63'd0, rsp_valid}, 64'd1);
    d = rsp_data;
    @(negedge clk);
    check("R9 response valid drops", {63'd0, rsp_valid}, 64'd0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic test_reset();
    logic [63:0] d;
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R1 rsp_data after reset", rsp_data, 64'd0);
    bus_read(A_IREG, 5, d); check("R1 cfg reset", d, 64'd0);
    bus_read(A_DREG, 6, d); check("R1 tag reset", d, 64'd0);
    bus_read(A_IREG, 0, d); check("R1 tag target reset", d, 64'd0);
  endtask

  task automatic test_regfile();
    logic [63:0] d;
    logic [63:0] v[3];
    for (int k = 0; k < 3; k++) v[k] = rnd64();
    bus_write(A_IREG, 5, v[0]);
    bus_write(A_IREG, 6, v[1]);
    bus_write(A_DREG, 9, v[2]);
    bus_read(A_IREG, 5, d); check("R2 I cfg readback", d, v[0]);
    bus_read(A_IREG, 6, d); check("R2 I tag readback", d, v[1]);
    bus_read(A_DREG, 9, d); check("R2 D idx9 readback", d, v[2]);
  endtask

  task automatic test_tag_target();
    logic [63:0] d, tag;
    tag = 64'hfedc_ba98_7654_3210;
    bus_write(A_DREG, 6, tag);
    bus_read(A_DREG, 0, d); check("R3 tag target", d, ref_tt(tag));
    bus_write(A_DREG, 0, 64'hffff_ffff_ffff_ffff);
    bus_read(A_DREG, 0, d); check("R3 index 0 write ignored", d, ref_tt(tag));
    bus_read(A_DREG, 6, d); check("R3 tag kept after idx0 write", d, tag);
  endtask

  task automatic test_ptr_sweep();
    logic [63:0] d, cfg, tag;
    for (int sp = 0; sp < 2; sp++) begin
      for (int sz = 0; sz < 16; sz++) begin
        cfg = rnd64();
        cfg[12] = 1'(sp); cfg[3:0] = 4'(sz);
        tag = rnd64();
        bus_write(A_DREG, 5, cfg);
        bus_write(A_DREG, 6, tag);
        bus_read(A_D8, 0, d);
        check(sp ? "R6 split 8K pointer" : "R4 R7 8K pointer size sweep", d, ref_ptr(cfg, tag, 1'b0));
        bus_read(A_D64, 0, d);
        check(sp ? "R6 split 64K pointer" : "R5 R7 64K pointer size sweep", d, ref_ptr(cfg, tag, 1'b1));
      end
    end
  endtask

  task automatic test_isolation();
    logic [63:0] d, icfg, itag;
    icfg = 64'h0123_4567_89ab_c000 | 64'h1003;
    itag = rnd64();
    bus_write(A_IREG, 5, icfg);
    bus_write(A_IREG, 6, itag);
    bus_write(A_DREG, 5, 64'h0000_0000_0000_000f);
    bus_write(A_DREG, 6, rnd64());
    bus_read(A_I8, 0, d);  check("R8 I 8K uses I regs", d, ref_ptr(icfg, itag, 1'b0));
    bus_read(A_I64, 0, d); check("R8 I 64K uses I regs", d, ref_ptr(icfg, itag, 1'b1));
    bus_read(A_IREG, 0, d); check("R8 I tag target uses I tag", d, ref_tt(itag));
  endtask

  task automatic test_unknown();
    logic [63:0] d;
    bus_read(8'h53, 5, d); check("R10 unknown ASI 0x53", d, 64'd0);
    bus_read(8'h00, 6, d); check("R10 unknown ASI 0x00", d, 64'd0);
  endtask

  task automatic test_ptr_write();
    logic [63:0] d, cfg, tag;
    cfg = 64'h0000_7777_0000_1004; tag = rnd64();
    bus_write(A_IREG, 5, cfg);
    bus_write(A_IREG, 6, tag);
    bus_write(A_I8, 5, 64'hdead_beef_dead_beef);
    bus_write(A_I64, 6, 64'hdead_beef_dead_beef);
    bus_read(A_IREG, 5, d); check("R11 cfg unchanged", d, cfg);
    bus_read(A_IREG, 6, d); check("R11 tag unchanged", d, tag);
    bus_read(A_I8, 0, d);   check("R11 8K pointer unchanged", d, ref_ptr(cfg, tag, 1'b0));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_regfile();
    test_tag_target();
    test_ptr_sweep();
    test_isolation();
    test_unknown();
    test_ptr_write();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule